// File: doc/BRIEF.md
# Masked Lookup Table with Staged Insertion

This block is a small associative lookup table. It holds sixteen 64-bit entries. A programmable key width splits each entry in two. The low `key_width` bits form the compare field. The bits above them, shifted down to bit 0, form the result field. A global don't-care mask removes chosen key bits from every comparison. The search port takes a key on every clock and returns a hit flag, the result field of the winning entry and a multiple-match flag. All three are registered.

The control port is separate from the search port. It is a 16-bit register interface. Software builds a 64-bit word from four 16-bit lanes, then pushes that word into a 12-deep insertion FIFO. A background drain moves one queued word per clock into the lowest-numbered free slot. Searches therefore run without stopping while new entries arrive. When every slot is occupied, the interrupt output is raised and queued words wait in the FIFO.

Several instances can be chained for more depth. `casc_in` reports a hit in an earlier, higher-priority instance. It suppresses the local result and is passed on through `casc_out`.

Top module: `cam_lookup`

## Requirements
- R1: After a synchronous reset:
  - the table is empty and the FIFO is empty;
  - the mask is all zeros, so every bit is compared;
  - the key width is 32;
  - `irq`, `m_hit` and `m_multi` are low;
  - the status word reads 0x0002.
- R2: Each control access lasts one cycle with `ctl_sel` high. An accepted access returns `ctl_ack` high in the following cycle. A read returns its data on `ctl_rdata` in that same cycle. Writes to addresses 0..3 set lane n (bits 16n+15..16n) of the staging word, and reads of those addresses return the lane.
- R3: A write to address 4 pushes the staging word into the FIFO. A pushed word is in the table in time for a key presented two cycles after the push cycle. Words fill free slots in push order, lowest slot first.
- R4: A write to address 5 sets the key width from `ctl_wdata[6:0]`. The value is clamped to the range 1..63. A read of address 5 returns the stored width.
- R5: An entry hits when its compare field equals the key on every low `key_width` bit whose mask bit is 0. Key bits at or above `key_width` are ignored. `m_data` is the entry shifted right by `key_width`, zero-filled. On a miss `m_data` is zero. Results appear one cycle after the key.
- R6: A write to address 6 copies the staging word into the mask. A mask bit of 1 makes that key bit don't-care.
- R7: When several entries hit, the lowest-numbered slot supplies `m_data`. `m_multi` is high when two or more entries hit.
- R8: The FIFO holds 12 words. A push while it is full is dropped and gets no `ctl_ack`. The status word at address 7 has these fields:
  - bit 0: FIFO full;
  - bit 1: FIFO empty;
  - bit 2: table full;
  - bits 7..4: FIFO count.
- R9: `irq` rises in the cycle after the drain fills the last free slot, and it stays high until reset. While the table is full, queued words remain unmatched.
- R10: While `casc_in` is high, `m_hit` and `m_multi` are low and `m_data` is zero. `casc_out` is high whenever `casc_in` is high or the local table hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_sel | input | 1 | Control access strobe |
| ctl_we | input | 1 | 1 = write, 0 = read |
| ctl_addr | input | 3 | Control register address |
| ctl_wdata | input | 16 | Control write data |
| ctl_rdata | output | 16 | Control read data |
| ctl_ack | output | 1 | Access acknowledge, one cycle after the access |
| irq | output | 1 | Table has no free slot |
| m_key | input | 64 | Search key |
| m_hit | output | 1 | Registered hit flag |
| m_multi | output | 1 | Registered multiple-hit flag |
| m_data | output | 64 | Result field of the winning entry |
| casc_in | input | 1 | Hit from a higher-priority instance |
| casc_out | output | 1 | Hit from this or an earlier instance |

## Verification
Control results (`ctl_ack`, `ctl_rdata`) are due one edge after the select cycle. Search results are due one edge after the key is applied. A pushed word becomes searchable at the second edge after its push, because it passes through the FIFO register and then the drain. `irq` follows the drain by one edge. The bench drives every input on a falling edge and samples exactly one rising edge later. Each search task is therefore started only after the push task has returned and one more falling edge has passed. The timing-exact `irq` check samples both before and after the drain edge.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int ENTRY_W  = 64;
  localparam int KW_W     = $clog2(ENTRY_W) + 1;
  localparam int KW_RESET = ENTRY_W / 2;

  typedef logic [ENTRY_W-1:0] entry_t;
  typedef logic [KW_W-1:0]    kw_t;

  // ones over the low kw bits: the compare field
  function automatic entry_t key_span(input kw_t kw);
    return (entry_t'(1) << kw) - entry_t'(1);
  endfunction

  function automatic kw_t clamp_kw(input kw_t raw);
    if (raw == '0) return kw_t'(1);
    if (raw >= kw_t'(ENTRY_W)) return kw_t'(ENTRY_W - 1);
    return raw;
  endfunction

  function automatic logic entry_hits(input entry_t ent, input entry_t key,
                                      input entry_t mask, input kw_t kw);
    return ((ent ^ key) & ~mask & key_span(kw)) == '0;
  endfunction

  function automatic entry_t out_field(input entry_t ent, input kw_t kw);
    return ent >> kw;
  endfunction
endpackage

// File: rtl/cam_ctl_port.sv
module cam_ctl_port
  import cam_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ack,
  input  logic          q_full,
  input  logic          q_empty,
  input  logic [CW-1:0] q_count,
  input  logic          tbl_full,
  output logic          push,
  output entry_t        stage,
  output entry_t        mask,
  output kw_t           kw
);
  localparam int LANES = ENTRY_W / DW;
  localparam logic [AW-1:0] A_PUSH = AW'(LANES);
  localparam logic [AW-1:0] A_KW   = AW'(LANES + 1);
  localparam logic [AW-1:0] A_MASK = AW'(LANES + 2);
  localparam logic [AW-1:0] A_STAT = AW'(LANES + 3);

  logic          wr, accept;
  logic [DW-1:0] rd_mux, status;

  assign wr     = sel & we;
  assign push   = wr & (addr == A_PUSH) & ~q_full;
  assign accept = sel & ~(we & (addr == A_PUSH) & q_full);
  assign status = DW'({q_count, 1'b0, tbl_full, q_empty, q_full});

  always_comb begin
    rd_mux = '0;
    if (addr < AW'(LANES))  rd_mux = stage[addr*DW +: DW];
    else if (addr == A_KW)  rd_mux = DW'(kw);
    else if (addr == A_STAT) rd_mux = status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
      mask  <= '0;
      kw    <= kw_t'(KW_RESET);
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= accept;
      if (sel && !we) rdata <= rd_mux;
      if (wr) begin
        if (addr < AW'(LANES)) stage[addr*DW +: DW] <= wdata;
        else if (addr == A_KW) kw <= clamp_kw(wdata[KW_W-1:0]);
        else if (addr == A_MASK) mask <= stage;
      end
    end
  end
endmodule

// File: rtl/cam_entry_fifo.sv
module cam_entry_fifo
  import cam_pkg::*;
#(
  parameter int QDEPTH = 12,
  parameter int CW = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  entry_t        din,
  input  logic          pop,
  output entry_t        dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(QDEPTH);

  entry_t        mem [QDEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(QDEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (count == CW'(QDEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= din;
        wp <= step(wp);
      end
      if (do_pop) rp <= step(rp);
      if (do_push && !do_pop) count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/cam_table.sv
module cam_table
  import cam_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_en,
  input  entry_t wr_data,
  input  entry_t key,
  input  entry_t mask,
  input  kw_t    kw,
  output logic   full,
  output logic   hit_q,
  output logic   multi_q,
  output entry_t data_q
);
  localparam int IW = $clog2(DEPTH);

  entry_t           ent [DEPTH];
  logic [DEPTH-1:0] valid, hits;
  logic [IW-1:0]    free_idx, win;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!valid[i]) begin free_idx = IW'(i); any_free = 1'b1; end
  end
  assign full = ~any_free;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hits[g] = valid[g] & entry_hits(ent[g], key, mask, kw);
  end

  always_comb begin
    win = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (hits[i]) win = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= '0;
      hit_q   <= 1'b0;
      multi_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (wr_en && any_free) begin
        valid[free_idx] <= 1'b1;
        ent[free_idx]   <= wr_data;
      end
      hit_q   <= |hits;
      multi_q <= $countones(hits) > 1;
      data_q  <= (|hits) ? out_field(ent[win], kw) : '0;
    end
  end
endmodule

// File: rtl/cam_lookup.sv
module cam_lookup
  import cam_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int QDEPTH = 12,
  parameter int DW     = 16,
  parameter int AW     = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_sel,
  input  logic               ctl_we,
  input  logic [AW-1:0]      ctl_addr,
  input  logic [DW-1:0]      ctl_wdata,
  output logic [DW-1:0]      ctl_rdata,
  output logic               ctl_ack,
  output logic               irq,
  input  logic [ENTRY_W-1:0] m_key,
  output logic               m_hit,
  output logic               m_multi,
  output logic [ENTRY_W-1:0] m_data,
  input  logic               casc_in,
  output logic               casc_out
);
  localparam int CW = $clog2(QDEPTH + 1);

  logic          q_full, q_empty, q_push, q_pop, tbl_full;
  logic [CW-1:0] q_count;
  entry_t        stage, mask, q_head, data_l;
  kw_t           kw;
  logic          hit_l, multi_l;

  cam_ctl_port #(.DW(DW), .AW(AW), .CW(CW)) u_ctl (
    .clk(clk), .rst(rst), .sel(ctl_sel), .we(ctl_we), .addr(ctl_addr),
    .wdata(ctl_wdata), .rdata(ctl_rdata), .ack(ctl_ack),
    .q_full(q_full), .q_empty(q_empty), .q_count(q_count), .tbl_full(tbl_full),
    .push(q_push), .stage(stage), .mask(mask), .kw(kw));

  assign q_pop = ~q_empty & ~tbl_full;

  cam_entry_fifo #(.QDEPTH(QDEPTH), .CW(CW)) u_fifo (
    .clk(clk), .rst(rst), .push(q_push), .din(stage), .pop(q_pop),
    .dout(q_head), .count(q_count), .full(q_full), .empty(q_empty));

  cam_table #(.DEPTH(DEPTH)) u_tbl (
    .clk(clk), .rst(rst), .wr_en(q_pop), .wr_data(q_head),
    .key(m_key), .mask(mask), .kw(kw), .full(tbl_full),
    .hit_q(hit_l), .multi_q(multi_l), .data_q(data_l));

  assign irq      = tbl_full;
  assign m_hit    = hit_l & ~casc_in;
  assign m_multi  = multi_l & ~casc_in;
  assign m_data   = casc_in ? '0 : data_l;
  assign casc_out = casc_in | hit_l;
endmodule

// File: rtl/cam_lookup_chk.sv
module cam_lookup_chk #(
  parameter int QDEPTH = 12,
  parameter int CW = $clog2(QDEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_sel,
  input logic          ctl_we,
  input logic [2:0]    ctl_addr,
  input logic          ctl_ack,
  input logic          irq,
  input logic          m_hit,
  input logic          m_multi,
  input logic          casc_in,
  input logic          casc_out,
  input logic [CW-1:0] q_count,
  input logic          q_full
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (q_count == '0 && !irq && !m_hit && !m_multi));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    q_count <= CW'(QDEPTH));
  // R8
  full_push_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_sel && ctl_we && ctl_addr == 3'd4 && q_full) |=> !ctl_ack);
  // R2
  ack_follows_sel_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_ack |-> $past(ctl_sel));
  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> irq);
  // R7
  multi_implies_hit_chk: assert property (@(posedge clk) disable iff (rst)
    m_multi |-> m_hit);
  // R10
  cascade_block_chk: assert property (@(posedge clk) disable iff (rst)
    casc_in |-> (!m_hit && !m_multi && casc_out));
endmodule

bind cam_lookup cam_lookup_chk #(.QDEPTH(QDEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ctl_sel(ctl_sel), .ctl_we(ctl_we),
  .ctl_addr(ctl_addr), .ctl_ack(ctl_ack), .irq(irq), .m_hit(m_hit),
  .m_multi(m_multi), .casc_in(casc_in), .casc_out(casc_out),
  .q_count(q_count), .q_full(q_full));

// File: tb/cam_lookup_tb.sv
module cam_lookup_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_sel = 1'b0, ctl_we = 1'b0;
  logic [2:0]  ctl_addr = '0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        ctl_ack, irq, m_hit, m_multi, casc_out;
  logic        casc_in = 1'b0;
  logic [63:0] m_key = '0;
  logic [63:0] m_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cam_lookup u_dut (
    .clk(clk), .rst(rst), .ctl_sel(ctl_sel), .ctl_we(ctl_we),
    .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .ctl_ack(ctl_ack), .irq(irq), .m_key(m_key), .m_hit(m_hit),
    .m_multi(m_multi), .m_data(m_data), .casc_in(casc_in),
    .casc_out(casc_out));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [63:0] key, input logic [63:0] res, input int w);
    logic [63:0] lowm = (64'd1 << w) - 64'd1;
    return (res << w) | (key & lowm);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; casc_in = 1'b0; m_key = '0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic ctl_op(input logic we, input logic [2:0] a, input logic [15:0] d,
                        output logic ack, output logic [15:0] rd);
    @(negedge clk);
    ctl_sel = 1'b1; ctl_we = we; ctl_addr = a; ctl_wdata = d;
    @(negedge clk);
    ack = ctl_ack; rd = ctl_rdata;
    ctl_sel = 1'b0; ctl_we = 1'b0;
  endtask

  task automatic load_stage(input logic [63:0] w);
    logic a; logic [15:0] r;
    for (int i = 0; i < 4; i++) ctl_op(1'b1, 3'(i), w[16*i +: 16], a, r);
  endtask

  task automatic push_entry(input logic [63:0] w, output logic ack);
    logic [15:0] r;
    load_stage(w);
    ctl_op(1'b1, 3'd4, 16'h0, ack, r);
  endtask

  task automatic search(input logic [63:0] k);
    @(negedge clk); m_key = k;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic a; logic [15:0] r;
    do_reset();
    chk("R1 irq", 64'(irq), 64'd0);
    ctl_op(1'b0, 3'd7, 16'h0, a, r);
    chk("R1 status", 64'(r), 64'h0002);
    chk("R2 read ack", 64'(a), 64'd1);
    ctl_op(1'b0, 3'd5, 16'h0, a, r);
    chk("R1 key width", 64'(r), 64'd32);
    search(64'h0);
    chk("R1 no hit", 64'(m_hit), 64'd0);
    chk("R2 ack idle", 64'(ctl_ack), 64'd0);
  endtask

  task automatic t_basic();
    logic a; logic [15:0] r;
    do_reset();
    load_stage(64'h1111_2222_3333_4444);
    ctl_op(1'b0, 3'd2, 16'h0, a, r);
    chk("R2 lane readback", 64'(r), 64'h2222);
    push_entry(mk(64'h1234_5678, 64'hCAFE, 32), a);
    chk("R3 push ack", 64'(a), 64'd1);
    search(64'hFFFF_FFFF_1234_5678);
    chk("R5 hit", 64'(m_hit), 64'd1);
    chk("R5 data", m_data, 64'hCAFE);
    chk("R7 single no multi", 64'(m_multi), 64'd0);
    search(64'h1234_5679);
    chk("R5 miss", 64'(m_hit), 64'd0);
    chk("R5 miss data", m_data, 64'd0);
    ctl_op(1'b1, 3'd5, 16'd16, a, r);
    search(64'h5678);
    chk("R4 narrow hit", 64'(m_hit), 64'd1);
    chk("R4 narrow data", m_data, 64'hCAFE_1234);
    ctl_op(1'b1, 3'd5, 16'd0, a, r);
    ctl_op(1'b0, 3'd5, 16'h0, a, r);
    chk("R4 clamp low", 64'(r), 64'd1);
    ctl_op(1'b1, 3'd5, 16'd100, a, r);
    ctl_op(1'b0, 3'd5, 16'h0, a, r);
    chk("R4 clamp high", 64'(r), 64'd63);
  endtask

  task automatic t_mask();
    logic a; logic [15:0] r;
    do_reset();
    push_entry(mk(64'h1234_5678, 64'h77, 32), a);
    load_stage(64'h0000_0000_0000_000F);
    ctl_op(1'b1, 3'd6, 16'h0, a, r);
    search(64'h1234_567F);
    chk("R6 masked hit", 64'(m_hit), 64'd1);
    chk("R6 masked data", m_data, 64'h77);
    search(64'h1234_5778);
    chk("R6 unmasked miss", 64'(m_hit), 64'd0);
  endtask

  task automatic t_priority();
    logic a; logic [15:0] r;
    do_reset();
    push_entry(mk(64'h55, 64'h1, 32), a);
    push_entry(mk(64'h55, 64'h2, 32), a);
    push_entry(mk(64'h66, 64'h3, 32), a);
    search(64'h55);
    chk("R7 lowest slot", m_data, 64'h1);
    chk("R7 multi", 64'(m_multi), 64'd1);
    search(64'h66);
    chk("R3 order data", m_data, 64'h3);
    chk("R7 one hit", 64'(m_multi), 64'd0);
    load_stage(64'hFF);
    ctl_op(1'b1, 3'd6, 16'h0, a, r);
    search(64'h0);
    chk("R7 all hit data", m_data, 64'h1);
    chk("R7 all hit multi", 64'(m_multi), 64'd1);
  endtask

  task automatic t_full();
    logic a; logic [15:0] r;
    do_reset();
    for (int i = 0; i < 16; i++) push_entry(mk(64'h100 + 64'(i), 64'hA0 + 64'(i), 32), a);
    chk("R9 irq before drain", 64'(irq), 64'd0);
    @(negedge clk);
    chk("R9 irq after drain", 64'(irq), 64'd1);
    for (int j = 0; j < 12; j++) begin
      push_entry(mk(64'h200 + 64'(j), 64'h5, 32), a);
      chk("R8 queued ack", 64'(a), 64'd1);
    end
    push_entry(mk(64'h300, 64'h6, 32), a);
    chk("R8 full nack", 64'(a), 64'd0);
    ctl_op(1'b0, 3'd7, 16'h0, a, r);
    chk("R8 status full", 64'(r), 64'h00C5);
    search(64'h10F);
    chk("R3 last slot data", m_data, 64'hAF);
    search(64'h200);
    chk("R9 queued unmatched", 64'(m_hit), 64'd0);
    chk("R9 irq held", 64'(irq), 64'd1);
  endtask

  task automatic t_cascade();
    logic a;
    do_reset();
    push_entry(mk(64'h42, 64'h9, 32), a);
    search(64'h42);
    chk("R10 local hit out", 64'(casc_out), 64'd1);
    casc_in = 1'b1;
    #1;
    chk("R10 suppressed hit", 64'(m_hit), 64'd0);
    chk("R10 suppressed data", m_data, 64'd0);
    chk("R10 pass through", 64'(casc_out), 64'd1);
    casc_in = 1'b0;
    search(64'h43);
    chk("R10 quiet out", 64'(casc_out), 64'd0);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_mask();
    t_priority();
    t_full();
    t_cascade();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule